// File: doc/BRIEF.md
# SM4 Byte-Slice T-Transform Unit

This unit performs one byte-wide step of the SM4 T transform. A 2-bit lane selector picks one byte of the second operand. That byte goes through the SM4 substitution box. The substituted byte, widened to a 32-bit word, then passes through one of two linear diffusion layers: the cipher-round layer or the key-expansion layer, chosen by a one-bit operation code. The word is rotated left so that its lane lines up with the selected byte, and it is XORed into the first operand. Running the unit four times, with lane selectors 0, 1, 2 and 3 and each result fed back as the next first operand, gives one complete SM4 round F(x0,x1,x2,x3,rk) = x0 ^ T(x1^x2^x3^rk). The second operand holds the XOR of x1, x2, x3 and rk throughout the four steps.

The datapath width XLEN is 32 or 64. With a 64-bit datapath, only the low 32 bits of each operand are used. A mode input selects how the 32-bit result fills the output word: sign-extended (64-bit mode) or zero-extended (32-bit mode). The substitution box is computed as affine map, field inversion and affine map, with no lookup memory. The latency is therefore one fixed cycle, whatever the data. An output register with a valid flag gives that one-cycle latency, and it can be removed by a parameter.

Top module: `sm4t_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted operation, out_valid is 0 and out_result is all zeros.
- R2: Only the two least significant bits of in_bsel are used. Value k selects byte in_rs2[8k+7:8k] as the substitution input, and the higher bits of in_bsel have no effect.
- R3: The substitution is the standard SM4 S-box. Examples: 0x00 maps to 0xD6, 0x01 to 0x90, 0x07 to 0xB7 and 0x0F to 0x05.
- R4: With in_op = 0 (cipher round), the zero-extended substituted byte b is transformed by L(b) = b ^ rol(b,2) ^ rol(b,10) ^ rol(b,18) ^ rol(b,24), where rol is a 32-bit left rotation.
- R5: With in_op = 1 (key expansion), the transform is L'(b) = b ^ rol(b,13) ^ rol(b,23).
- R6: The transformed word is rotated left by 8*k bits, where k is the lane selector, and XORed with in_rs1[31:0] to form the 32-bit result.
- R7: With in_xl64 = 1 and XLEN = 64, out_result is the 32-bit result sign-extended from bit 31. Bits 63:32 of in_rs1 and in_rs2 have no effect.
- R8: With in_xl64 = 0 and XLEN = 64, out_result[63:32] is zero.
- R9: With the output register present, out_valid is 1 exactly in the cycle after each cycle with in_valid = 1, and the result of that operation is on out_result in that cycle. Back-to-back operations come out in order, one per cycle.
- R10: In a cycle with in_valid = 0, out_result keeps its value in the following cycle, whatever the other inputs do, and out_valid is 0.
- R11: Four chained operations with lane selectors 0, 1, 2 and 3, starting from x0 and keeping the same a, give x0 ^ L(S(a)). Here S applies the S-box to each byte of a in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 1 | 0 = cipher-round layer, 1 = key-expansion layer |
| in_xl64 | input | 1 | 1 = sign-extend result (64-bit mode), 0 = zero-extend |
| in_bsel | input | BSEL_W (5) | Lane selector, only bits 1:0 used |
| in_rs1 | input | XLEN (64) | Accumulator operand, low 32 bits used |
| in_rs2 | input | XLEN (64) | Operand holding the byte to substitute, low 32 bits used |
| out_valid | output | 1 | Result valid |
| out_result | output | XLEN (64) | Extended result |

## Verification
The bench puts a known byte in each of the four lanes of in_rs2, fills the other lanes with bytes that differ, and sets the upper bits of the selector. A lane multiplexer that is wired wrong, or that decodes too many selector bits, would then substitute the wrong byte. Both diffusion layers are checked on the same bytes, so swapped or mistyped rotation taps show up as a wrong result word. The 64-bit checks put junk in the upper operand halves and use results of both signs in each extension mode, which exposes a wrong extension bit or upper bits that leak through. A four-step chain is compared with a whole-word round computed in the bench, and a hold phase changes every input while in_valid is low: a result register that loads without a request, or a valid flag that lingers, would change the output.

// File: rtl/sm4t_pkg.sv
package sm4t_pkg;

   localparam int unsigned SM4T_BYTE_W = 8;
   localparam int unsigned SM4T_LANES  = 4;
   localparam int unsigned SM4T_WORD_W = SM4T_BYTE_W * SM4T_LANES;

   typedef enum logic {
      SM4T_OP_ROUND  = 1'b0,
      SM4T_OP_KEYEXP = 1'b1
   } sm4t_op_e;

   typedef logic [SM4T_WORD_W-1:0] sm4t_word_t;
   typedef logic [SM4T_BYTE_W-1:0] sm4t_byte_t;

   // rotation taps of the two diffusion layers (bit 0 term is implicit)
   localparam int unsigned SM4T_ROUND_NTAP = 4;
   localparam int unsigned SM4T_KEY_NTAP   = 2;
   localparam int unsigned SM4T_ROUND_TAPS [SM4T_ROUND_NTAP] = '{2, 10, 18, 24};
   localparam int unsigned SM4T_KEY_TAPS   [SM4T_KEY_NTAP]   = '{13, 23};

   // field and affine constants of the substitution box
   localparam logic [7:0] SM4T_GF_REDUCE = 8'hF5;  // x^8 = x^7+x^6+x^5+x^4+x^2+1
   localparam logic [7:0] SM4T_AFF_ROW   = 8'hA7;  // circulant row seed
   localparam logic [7:0] SM4T_AFF_CONST = 8'hD3;

endpackage

// File: rtl/sm4t_lane_pick.sv
module sm4t_lane_pick #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned SEL_W  = 5
) (
   input  logic [LANES*BYTE_W-1:0] src_word,
   input  logic [SEL_W-1:0]        sel,
   output logic [BYTE_W-1:0]       lane_byte
);

   localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   logic [BYTE_W-1:0] lanes [LANES];
   logic [IDX_W-1:0]  idx;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lanes[g] = src_word[g*BYTE_W +: BYTE_W];
      end

      if (SEL_W > IDX_W) begin : g_sel_trim
         logic unused_sel_hi;
         assign unused_sel_hi = ^sel[SEL_W-1:IDX_W];
         assign idx = sel[IDX_W-1:0];
      end else begin : g_sel_exact
         assign idx = sel;
      end
   endgenerate

   assign lane_byte = lanes[idx];

endmodule

// File: rtl/sm4t_sbox.sv
module sm4t_sbox
   import sm4t_pkg::*;
#(
   parameter logic [7:0] REDUCE    = SM4T_GF_REDUCE,
   parameter logic [7:0] ROW_SEED  = SM4T_AFF_ROW,
   parameter logic [7:0] AFF_CONST = SM4T_AFF_CONST
) (
   input  logic [7:0] sb_in,
   output logic [7:0] sb_out
);

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = sh[7] ? ((sh << 1) ^ REDUCE) : (sh << 1);
      end
      return acc;
   endfunction

   // x^254 by a fixed square-and-multiply chain; zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] x);
      logic [7:0] pw;
      logic [7:0] prod;
      pw   = x;
      prod = 8'h01;
      for (int k = 1; k < 8; k++) begin
         pw   = gf_mul(pw, pw);
         prod = gf_mul(prod, pw);
      end
      return prod;
   endfunction

   function automatic logic [7:0] rot_seed(input int unsigned n);
      logic [15:0] dbl;
      dbl = {ROW_SEED, ROW_SEED} << n;
      return dbl[15:8];
   endfunction

   logic [7:0] pre_aff;
   logic [7:0] inv_val;
   logic [7:0] post_aff;

   generate
      for (genvar r = 0; r < 8; r++) begin : g_aff
         localparam logic [7:0] ROW_MASK = rot_seed(r);
         assign pre_aff[r]  = ^(sb_in   & ROW_MASK) ^ AFF_CONST[r];
         assign post_aff[r] = ^(inv_val & ROW_MASK) ^ AFF_CONST[r];
      end
   endgenerate

   assign inv_val = gf_inv(pre_aff);
   assign sb_out  = post_aff;

endmodule

// File: rtl/sm4t_linear.sv
module sm4t_linear
   import sm4t_pkg::*;
#(
   parameter int unsigned WORD_W = SM4T_WORD_W,
   parameter int unsigned BYTE_W = SM4T_BYTE_W
) (
   input  logic [BYTE_W-1:0] sb_byte,
   input  logic              key_form,
   output logic [WORD_W-1:0] lin_word
);

   logic [WORD_W-1:0] wide;
   logic [WORD_W-1:0] racc [SM4T_ROUND_NTAP+1];
   logic [WORD_W-1:0] kacc [SM4T_KEY_NTAP+1];

   assign wide    = {{(WORD_W-BYTE_W){1'b0}}, sb_byte};
   assign racc[0] = wide;
   assign kacc[0] = wide;

   generate
      for (genvar g = 0; g < SM4T_ROUND_NTAP; g++) begin : g_round_tap
         localparam int unsigned SH = SM4T_ROUND_TAPS[g];
         assign racc[g+1] = racc[g] ^ ((wide << SH) | (wide >> (WORD_W - SH)));
      end
      for (genvar g = 0; g < SM4T_KEY_NTAP; g++) begin : g_key_tap
         localparam int unsigned SH = SM4T_KEY_TAPS[g];
         assign kacc[g+1] = kacc[g] ^ ((wide << SH) | (wide >> (WORD_W - SH)));
      end
   endgenerate

   assign lin_word = key_form ? kacc[SM4T_KEY_NTAP] : racc[SM4T_ROUND_NTAP];

endmodule

// File: rtl/sm4t_lane_rot.sv
module sm4t_lane_rot #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned SEL_W  = 5
) (
   input  logic [LANES*BYTE_W-1:0] in_word,
   input  logic [SEL_W-1:0]        sel,
   output logic [LANES*BYTE_W-1:0] out_word
);

   localparam int unsigned WORD_W = LANES * BYTE_W;
   localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;

   logic [WORD_W-1:0] rots [LANES];
   logic [IDX_W-1:0]  idx;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_rot
         localparam int unsigned SH = g * BYTE_W;
         if (SH == 0) begin : g_none
            assign rots[g] = in_word;
         end else begin : g_shift
            assign rots[g] = (in_word << SH) | (in_word >> (WORD_W - SH));
         end
      end

      if (SEL_W > IDX_W) begin : g_sel_trim
         logic unused_rot_sel;
         assign unused_rot_sel = ^sel[SEL_W-1:IDX_W];
         assign idx = sel[IDX_W-1:0];
      end else begin : g_sel_exact
         assign idx = sel;
      end
   endgenerate

   assign out_word = rots[idx];

endmodule

// File: rtl/sm4t_outstage.sv
module sm4t_outstage #(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned WORD_W  = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_xl64,
   input  logic [WORD_W-1:0] res_word,
   output logic              out_valid,
   output logic [XLEN-1:0]   out_result
);

   logic [XLEN-1:0] ext_word;

   generate
      if (XLEN > WORD_W) begin : g_wide
         logic fill;
         assign fill     = in_xl64 & res_word[WORD_W-1];
         assign ext_word = {{(XLEN-WORD_W){fill}}, res_word};
      end else begin : g_narrow
         logic unused_mode;
         assign unused_mode = in_xl64;
         assign ext_word    = res_word;
      end

      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid  <= 1'b0;
               out_result <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) out_result <= ext_word;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign out_valid  = in_valid;
         assign out_result = ext_word;
      end
   endgenerate

endmodule

// File: rtl/sm4t_unit.sv
module sm4t_unit
   import sm4t_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned BSEL_W  = 5,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_op,
   input  logic              in_xl64,
   input  logic [BSEL_W-1:0] in_bsel,
   input  logic [XLEN-1:0]   in_rs1,
   input  logic [XLEN-1:0]   in_rs2,
   output logic              out_valid,
   output logic [XLEN-1:0]   out_result
);

   localparam int unsigned WORD_W = SM4T_WORD_W;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("sm4t_unit: XLEN must be 32 or 64");
      end
      if (BSEL_W < 2) begin : g_bad_bsel
         $error("sm4t_unit: BSEL_W must be at least 2");
      end
   endgenerate

   sm4t_word_t a_word;
   sm4t_word_t x_word;
   sm4t_byte_t pick_byte;
   sm4t_byte_t sub_byte;
   sm4t_word_t lin_word;
   sm4t_word_t placed_word;
   sm4t_word_t res_word;
   sm4t_op_e   op_kind;

   assign op_kind = sm4t_op_e'(in_op);
   assign a_word  = in_rs2[WORD_W-1:0];
   assign x_word  = in_rs1[WORD_W-1:0];

   generate
      if (XLEN > WORD_W) begin : g_hi_drop
         logic unused_hi;
         assign unused_hi = ^{in_rs1[XLEN-1:WORD_W], in_rs2[XLEN-1:WORD_W]};
      end
   endgenerate

   sm4t_lane_pick #(
      .LANES (SM4T_LANES),
      .BYTE_W(SM4T_BYTE_W),
      .SEL_W (BSEL_W)
   ) u_pick (
      .src_word (a_word),
      .sel      (in_bsel),
      .lane_byte(pick_byte)
   );

   sm4t_sbox u_sbox (
      .sb_in (pick_byte),
      .sb_out(sub_byte)
   );

   sm4t_linear #(
      .WORD_W(WORD_W),
      .BYTE_W(SM4T_BYTE_W)
   ) u_lin (
      .sb_byte (sub_byte),
      .key_form(op_kind == SM4T_OP_KEYEXP),
      .lin_word(lin_word)
   );

   sm4t_lane_rot #(
      .LANES (SM4T_LANES),
      .BYTE_W(SM4T_BYTE_W),
      .SEL_W (BSEL_W)
   ) u_rot (
      .in_word (lin_word),
      .sel     (in_bsel),
      .out_word(placed_word)
   );

   assign res_word = placed_word ^ x_word;

   sm4t_outstage #(
      .XLEN   (XLEN),
      .WORD_W (WORD_W),
      .OUT_REG(OUT_REG)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_xl64   (in_xl64),
      .res_word  (res_word),
      .out_valid (out_valid),
      .out_result(out_result)
   );

endmodule

// File: rtl/sm4t_unit_chk.sv
module sm4t_unit_chk #(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned BSEL_W  = 5,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_xl64,
   input logic              out_valid,
   input logic [XLEN-1:0]   out_result
);

   generate
      if (OUT_REG) begin : g_seq
         // R1: outputs cleared while reset is held
         a_r1_reset_clear: assert property (@(posedge clk)
            !rst_n |-> (!out_valid && out_result == '0));

         // R9: fixed one-cycle latency of the valid flag
         a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

         // R10: result held when nothing is requested
         a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_result));

         if (XLEN > 32) begin : g_ext
            // R7: sign extension in 64-bit mode
            a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
               (in_valid && in_xl64) |=>
                  (out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}}));
            // R8: zero upper half in 32-bit mode
            a_r8_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
               (in_valid && !in_xl64) |=> (out_result[XLEN-1:32] == '0));
         end
      end
   endgenerate

endmodule

bind sm4t_unit sm4t_unit_chk #(
   .XLEN   (XLEN),
   .BSEL_W (BSEL_W),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_xl64   (in_xl64),
   .out_valid (out_valid),
   .out_result(out_result)
);

// File: tb/test_sm4t_unit.sv
module test_sm4t_unit;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 64;
   localparam int BSEL_W     = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_op = 1'b0;
   logic              in_xl64 = 1'b1;
   logic [BSEL_W-1:0] in_bsel = '0;
   logic [XLEN-1:0]   in_rs1 = '0;
   logic [XLEN-1:0]   in_rs2 = '0;
   logic              out_valid;
   logic [XLEN-1:0]   out_result;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // known S-box outputs for inputs 0x00..0x0F (R3)
   logic [7:0] sb_known [16] = '{8'hD6, 8'h90, 8'hE9, 8'hFE, 8'hCC, 8'hE1, 8'h3D, 8'hB7,
                                 8'h16, 8'hB6, 8'h14, 8'hC2, 8'h28, 8'hFB, 8'h2C, 8'h05};

   sm4t_unit #(.XLEN(XLEN), .BSEL_W(BSEL_W), .OUT_REG(1'b1)) i_sm4t_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_xl64(in_xl64),
      .in_bsel(in_bsel), .in_rs1(in_rs1), .in_rs2(in_rs2),
      .out_valid(out_valid), .out_result(out_result)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] rol(input logic [31:0] w, input int n);
      if (n == 0) return w;
      return (w << n) | (w >> (32 - n));
   endfunction

   function automatic logic [31:0] l_round(input logic [31:0] b);
      return b ^ rol(b, 2) ^ rol(b, 10) ^ rol(b, 18) ^ rol(b, 24);
   endfunction

   function automatic logic [31:0] l_key(input logic [31:0] b);
      return b ^ rol(b, 13) ^ rol(b, 23);
   endfunction

   // expected value from R2..R8; selected byte must be below 0x10
   function automatic logic [XLEN-1:0] expect_op(input logic [XLEN-1:0] rs1,
                                                input logic [XLEN-1:0] rs2,
                                                input logic [BSEL_W-1:0] bsel,
                                                input logic op, input logic xl64);
      int         k;
      logic [7:0] byt;
      logic [31:0] c;
      logic [31:0] r;
      k   = int'(bsel[1:0]);
      byt = rs2[8*k +: 8];
      c   = {24'h0, sb_known[byt[3:0]]};
      c   = op ? l_key(c) : l_round(c);
      r   = rol(c, 8*k) ^ rs1[31:0];
      return xl64 ? {{32{r[31]}}, r} : {32'h0, r};
   endfunction

   task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // apply one operation and check it one cycle later
   task automatic run_op(input string tag, input logic [XLEN-1:0] rs1, input logic [XLEN-1:0] rs2,
                         input logic [BSEL_W-1:0] bsel, input logic op, input logic xl64);
      @(negedge clk);
      in_rs1 = rs1; in_rs2 = rs2; in_bsel = bsel; in_op = op; in_xl64 = xl64;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " valid (R9)"}, {63'h0, out_valid}, 64'h1);
      check(tag, out_result, expect_op(rs1, rs2, bsel, op, xl64));
   endtask

   task automatic t_reset;
      check("R1 reset valid", {63'h0, out_valid}, 64'h0);
      check("R1 reset result", out_result, 64'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release valid", {63'h0, out_valid}, 64'h0);
      check("R1 after release result", out_result, 64'h0);
   endtask

   task automatic t_lanes;
      // known byte in lane k, distinct bytes elsewhere (R2, R3, R4, R6)
      run_op("R2 R3 R4 lane0", 64'h0, 64'h0000_0000_AB_CD_EF_00, 5'd0, 1'b0, 1'b1);
      run_op("R2 R3 R4 lane1", 64'h0, 64'h0000_0000_AB_CD_07_EE, 5'd1, 1'b0, 1'b1);
      run_op("R2 R3 R6 lane2", 64'h0, 64'h0000_0000_AB_0F_EF_EE, 5'd2, 1'b0, 1'b1);
      run_op("R2 R3 R6 lane3", 64'h0000_0000_1357_9BDF, 64'h0000_0000_01_CD_EF_EE, 5'd3, 1'b0, 1'b1);
      run_op("R6 rs1 xor", 64'h0000_0000_F0F0_5A5A, 64'h0000_0000_FF_FF_0C_FF, 5'd1, 1'b0, 1'b1);
   endtask

   task automatic t_bsel_hi;
      // upper selector bits set: 5'b10110 and 5'b11101 select lanes 2 and 1 (R2)
      run_op("R2 upper bsel lane2", 64'h0, 64'h0000_0000_EE_03_DD_CC, 5'b10110, 1'b0, 1'b1);
      run_op("R2 upper bsel lane1", 64'h0, 64'h0000_0000_EE_DD_0A_CC, 5'b11101, 1'b0, 1'b1);
   endtask

   task automatic t_key;
      run_op("R5 key lane0", 64'h0, 64'h0000_0000_0000_0005, 5'd0, 1'b1, 1'b1);
      run_op("R5 key lane3", 64'h0000_0000_89AB_CDEF, 64'h0000_0000_0E00_0000, 5'd3, 1'b1, 1'b1);
   endtask

   task automatic t_wide;
      // junk in upper halves, both result signs (R7)
      run_op("R7 sext negative", 64'hDEAD_BEEF_0000_0000, 64'hFFFF_FFFF_0000_0001, 5'd0, 1'b0, 1'b1);
      run_op("R7 sext positive", 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_0000_0001, 5'd0, 1'b0, 1'b1);
      // zero extension in 32-bit mode (R8)
      run_op("R8 zext negative", 64'hFFFF_0000_0000_0000, 64'hAAAA_5555_0000_0001, 5'd0, 1'b0, 1'b0);
      run_op("R8 zext positive", 64'h0F0F_0F0F_8000_0000, 64'h0000_0000_0000_0001, 5'd0, 1'b0, 1'b0);
   endtask

   task automatic t_back2back;
      logic [XLEN-1:0] e1, e2;
      e1 = expect_op(64'h0, 64'h0000_0000_0000_0002, 5'd0, 1'b0, 1'b1);
      e2 = expect_op(64'h0000_0000_1111_2222, 64'h0000_0000_0000_0800, 5'd1, 1'b1, 1'b1);
      @(negedge clk);
      in_rs1 = 64'h0; in_rs2 = 64'h0000_0000_0000_0002; in_bsel = 5'd0; in_op = 1'b0;
      in_xl64 = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      check("R9 b2b first", out_result, e1);
      in_rs1 = 64'h0000_0000_1111_2222; in_rs2 = 64'h0000_0000_0000_0800; in_bsel = 5'd1; in_op = 1'b1;
      @(negedge clk);
      check("R9 b2b second", out_result, e2);
      check("R9 b2b valid", {63'h0, out_valid}, 64'h1);
      in_valid = 1'b0;
      @(negedge clk);
      check("R9 valid drops", {63'h0, out_valid}, 64'h0);
   endtask

   task automatic t_hold;
      logic [XLEN-1:0] kept;
      run_op("R10 setup", 64'h0000_0000_0BAD_F00D, 64'h0000_0000_0000_0900, 5'd1, 1'b0, 1'b1);
      kept = expect_op(64'h0000_0000_0BAD_F00D, 64'h0000_0000_0000_0900, 5'd1, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) begin
         in_rs1 = 64'hFFFF_FFFF_FFFF_FFFF - 64'(i); in_rs2 = 64'h0000_0000_0403_0201;
         in_bsel = 5'(i); in_op = ~in_op; in_xl64 = ~in_xl64;
         @(negedge clk);
         check("R10 hold result", out_result, kept);
         check("R10 hold valid", {63'h0, out_valid}, 64'h0);
      end
   endtask

   task automatic t_round;
      logic [31:0] a, x0, sword;
      logic [XLEN-1:0] acc;
      a  = 32'h0C07_020E;
      x0 = 32'h0123_4567;
      sword = {sb_known[4'hC], sb_known[4'h7], sb_known[4'h2], sb_known[4'hE]};
      acc = {32'h0, x0};
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         in_rs1 = acc; in_rs2 = {32'h0, a}; in_bsel = 5'(k); in_op = 1'b0;
         in_xl64 = 1'b0; in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         acc = out_result;
      end
      check("R11 full round", acc, {32'h0, x0 ^ l_round(sword)});
   endtask

   initial begin
      t_reset();
      t_lanes();
      t_bsel_hi();
      t_key();
      t_wide();
      t_back2back();
      t_hold();
      t_round();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule